// File: doc/BRIEF.md
# Reset Sequencer with Watchdog

This block generates the processor's single internal reset. Three sources can hold that reset. The first is a power-on stabilization delay. The second is an external active-low reset pin. The third is a watchdog time-out. After the oscillator reports that it is running, the block counts a fixed number of processor clock cycles before it releases reset. Any other source that is still active at the end of that count keeps reset asserted until that source ends. The oscillator, the analog over-voltage detector on the interrupt pin and the timer prescaler are outside the block. Each of them reaches it as a plain digital input.

The watchdog counts ticks that come from an external divider. When the count reaches a limit, the watchdog forces a short reset. Software prevents this by writing a word with bit 0 clear to the service address. Reads from that address do not return watchdog state. They return a fixed byte, the high half of a timer interrupt vector. Two conditions turn the watchdog off. One is a static configuration bit. The other is the interrupt-pin over-voltage flag: the block samples it at the clock edge where internal reset is released, and the sampled value holds until the next release.

Top module: `rst_wdog_seq`

## Requirements
- R1: After `osc_ok` goes high, `core_rst` stays 1 for exactly `POR_CYCLES` rising clock edges, counted from the first edge that samples `osc_ok` high. It falls after the next edge, provided no other source is active.
- R2: `osc_ok` low sets `core_rst` to 1 after the next edge. When `osc_ok` rises again, the power-on count starts over from zero.
- R3: The pin `ext_rst_n` passes through `SYNC_STAGES` synchronizer flops. A level change on the pin therefore reaches `core_rst` `SYNC_STAGES`+1 edges later. If the pin is still low when the power-on count ends, `core_rst` stays 1 until the released pin has passed through the synchronizer.
- R4: With the watchdog enabled, suppose the counter has seen `TIMEOUT_TICKS` ticks since it was last cleared. Then `core_rst` rises one edge after the edge that sampled the final tick. It stays 1 for two cycles and then falls.
- R5: A bus write (`bus_wr`=1) clears the watchdog counter when `bus_addr` equals `SVC_ADDR` and `bus_wdata[0]` is 0. A clear takes priority over a tick in the same cycle. A write with bit 0 set, or a write to any other address, leaves the counter unchanged.
- R6: `bus_rdata` equals `VEC_HI` when `bus_rd`=1 and `bus_addr`=`SVC_ADDR`. In every other case it is 0, and writes never change it.
- R7: While `wdog_cfg_en` is 0, ticks do not advance the watchdog counter and no time-out occurs.
- R8: `irq_hv` is sampled at the edge where `core_rst` falls. If the sample is 1, the watchdog is disabled until a later release samples 0. From that release on, the watchdog runs again, provided `wdog_cfg_en` is 1.
- R9: While `core_rst` is 1, the watchdog counter and time-out are held clear, so ticks during reset do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| osc_ok | input | 1 | Oscillator running flag; low restarts the power-on delay |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdog_cfg_en | input | 1 | Static watchdog enable configuration bit |
| irq_hv | input | 1 | Interrupt pin over-voltage detect flag |
| wdog_tick | input | 1 | One-cycle watchdog tick from the timer divider |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| core_rst | output | 1 | Internal reset, active high |
| bus_rdata | output | 8 | Read data for the shared service address |

## Verification
The power-on path is tested three ways: with a clean start, with an oscillator drop partway through the count, and with the pin held low past the count. These three cases separate a delay that restarts from one that only pauses, and a release that depends only on the count from one that also waits for the other sources. The watchdog is driven with runs of back-to-back ticks just below and exactly at the limit. This pins down the off-by-one and the length of the reset pulse. A random mix of ticks and of valid, bit-0-set and wrong-address writes, some landing in the same cycle as a tick, shows whether only the correct service write clears the count. Pulses on the reset pin with the over-voltage flag high and then low show that the disable is latched at release and that a later release with the flag low turns the watchdog back on.

// File: rtl/rsw_pkg.sv
package rsw_pkg;

    // One bit per reset source that can hold the internal reset.
    typedef struct packed {
        logic por_busy;   // stabilization count still running
        logic pin_low;    // synchronized pin is asserted
        logic wdog_fire;  // watchdog time-out pending
    } rst_src_t;

    function automatic logic src_active(rst_src_t s);
        return s.por_busy | s.pin_low | s.wdog_fire;
    endfunction

endpackage

// File: rtl/rsw_por_timer.sv
module rsw_por_timer #(
    parameter int POR_CYCLES = 4064
) (
    input  logic clk,
    input  logic osc_ok,
    output logic por_done
);
    localparam int CW = $clog2(POR_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } por_st_t;

    por_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!osc_ok) begin
            st_d = '0;
        end else if (!st_q.done) begin
            if (st_q.cnt == CW'(POR_CYCLES - 1)) begin
                st_d.done = 1'b1;
            end
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign por_done = st_q.done;

endmodule

// File: rtl/rsw_pin_sync.sv
module rsw_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic osc_ok,
    input  logic pin_n,
    output logic pin_ok
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                sh_d = osc_ok ? pin_n : 1'b0;
            end
        end else begin : g_chain
            always_comb begin
                if (!osc_ok) begin
                    sh_d = '0;
                end else begin
                    sh_d = {sh_q[STAGES-2:0], pin_n};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        sh_q <= sh_d;
    end

    assign pin_ok = sh_q[STAGES-1];

endmodule

// File: rtl/rsw_wdog.sv
module rsw_wdog #(
    parameter int              TIMEOUT_TICKS = 65536,
    parameter int              ADDR_W        = 12,
    parameter logic [ADDR_W-1:0] SVC_ADDR    = 12'hFF0
) (
    input  logic              clk,
    input  logic              osc_ok,
    input  logic              hold,
    input  logic              release_evt,
    input  logic              irq_hv,
    input  logic              cfg_en,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wdata_b0,
    output logic              fire
);
    localparam int CW = $clog2(TIMEOUT_TICKS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fire;
        logic          off;   // disabled by over-voltage seen at release
    } wd_st_t;

    wd_st_t st_d, st_q;
    logic   svc_hit;
    logic   active;

    always_comb begin
        svc_hit = bus_wr && (bus_addr == SVC_ADDR) && !wdata_b0;
        active  = cfg_en && !st_q.off;
        st_d    = st_q;
        if (!osc_ok) begin
            st_d = '0;
        end else begin
            if (release_evt) begin
                st_d.off = irq_hv;
            end
            if (hold) begin
                st_d.cnt  = '0;
                st_d.fire = 1'b0;
            end else if (svc_hit) begin
                st_d.cnt = '0;
            end else if (active && tick) begin
                if (st_q.cnt == CW'(TIMEOUT_TICKS - 1)) begin
                    st_d.fire = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fire = st_q.fire;

endmodule

// File: rtl/rst_wdog_seq.sv
module rst_wdog_seq #(
    parameter int                POR_CYCLES    = 4064,
    parameter int                SYNC_STAGES   = 2,
    parameter int                TIMEOUT_TICKS = 65536,
    parameter int                ADDR_W        = 12,
    parameter logic [ADDR_W-1:0] SVC_ADDR      = 12'hFF0,
    parameter logic [7:0]        VEC_HI        = 8'h00
) (
    input  logic              clk,
    input  logic              osc_ok,
    input  logic              ext_rst_n,
    input  logic              wdog_cfg_en,
    input  logic              irq_hv,
    input  logic              wdog_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic              core_rst,
    output logic [7:0]        bus_rdata
);
    import rsw_pkg::*;

    typedef struct packed {
        logic rst;
    } top_st_t;

    top_st_t  st_d, st_q;
    rst_src_t src;
    logic     por_done;
    logic     pin_ok;
    logic     wdog_fire;
    logic     release_evt;
    logic     unused_wdata;

    assign unused_wdata = ^bus_wdata[7:1];

    rsw_por_timer #(
        .POR_CYCLES(POR_CYCLES)
    ) u_por (
        .clk      (clk),
        .osc_ok   (osc_ok),
        .por_done (por_done)
    );

    rsw_pin_sync #(
        .STAGES(SYNC_STAGES)
    ) u_pin (
        .clk    (clk),
        .osc_ok (osc_ok),
        .pin_n  (ext_rst_n),
        .pin_ok (pin_ok)
    );

    rsw_wdog #(
        .TIMEOUT_TICKS(TIMEOUT_TICKS),
        .ADDR_W       (ADDR_W),
        .SVC_ADDR     (SVC_ADDR)
    ) u_wdog (
        .clk         (clk),
        .osc_ok      (osc_ok),
        .hold        (st_q.rst),
        .release_evt (release_evt),
        .irq_hv      (irq_hv),
        .cfg_en      (wdog_cfg_en),
        .tick        (wdog_tick),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .wdata_b0    (bus_wdata[0]),
        .fire        (wdog_fire)
    );

    always_comb begin
        src.por_busy  = !por_done;
        src.pin_low   = !pin_ok;
        src.wdog_fire = wdog_fire;
        st_d.rst      = !osc_ok || src_active(src);
        release_evt   = st_q.rst && !st_d.rst;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        if (bus_rd && (bus_addr == SVC_ADDR)) begin
            bus_rdata = VEC_HI;
        end else begin
            bus_rdata = '0;
        end
    end

    assign core_rst = st_q.rst;

endmodule

// File: rtl/rsw_chk.sv
module rsw_chk #(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] SVC_ADDR = 12'hFF0,
    parameter logic [7:0]        VEC_HI   = 8'h00
) (
    input logic              clk,
    input logic              osc_ok,
    input logic              core_rst,
    input logic              por_done,
    input logic              pin_ok,
    input logic              wdog_fire,
    input logic              wdog_cfg_en,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata
);

    p_por_hold_r1: assert property (@(posedge clk) disable iff (!osc_ok)
        !por_done |=> core_rst);

    p_release_clean_r1: assert property (@(posedge clk) disable iff (!osc_ok)
        $fell(core_rst) |-> (por_done && $past(pin_ok) && !$past(wdog_fire)));

    p_osc_low_r2: assert property (@(posedge clk)
        !osc_ok |=> core_rst);

    p_pin_hold_r3: assert property (@(posedge clk) disable iff (!osc_ok)
        !pin_ok |=> core_rst);

    p_fire_rst_r4: assert property (@(posedge clk) disable iff (!osc_ok)
        wdog_fire |=> core_rst);

    p_rdata_only_svc_r6: assert property (@(posedge clk) disable iff (!osc_ok)
        (bus_rdata != 8'h00) |-> (bus_rd && bus_addr == SVC_ADDR && bus_rdata == VEC_HI));

    p_cfg_off_r7: assert property (@(posedge clk) disable iff (!osc_ok)
        $rose(wdog_fire) |-> $past(wdog_cfg_en));

    p_rst_clears_r9: assert property (@(posedge clk) disable iff (!osc_ok)
        core_rst |=> !wdog_fire);

endmodule

bind rst_wdog_seq rsw_chk #(
    .ADDR_W  (ADDR_W),
    .SVC_ADDR(SVC_ADDR),
    .VEC_HI  (VEC_HI)
) u_chk (
    .clk        (clk),
    .osc_ok     (osc_ok),
    .core_rst   (core_rst),
    .por_done   (por_done),
    .pin_ok     (pin_ok),
    .wdog_fire  (wdog_fire),
    .wdog_cfg_en(wdog_cfg_en),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata)
);

// File: tb/rst_wdog_seq_tb.sv
module rst_wdog_seq_tb;
    localparam int          P   = 4064;
    localparam int          SY  = 2;
    localparam int          T   = 8;
    localparam int          AW  = 12;
    localparam logic [11:0] SVC = 12'hFF0;
    localparam logic [7:0]  VEC = 8'hA5;

    logic          clk = 1'b0;
    logic          osc_ok, ext_rst_n, wdog_cfg_en, irq_hv, wdog_tick;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic          bus_wr, bus_rd;
    logic          core_rst;
    logic [7:0]    bus_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rst_wdog_seq #(
        .POR_CYCLES(P), .SYNC_STAGES(SY), .TIMEOUT_TICKS(T),
        .ADDR_W(AW), .SVC_ADDR(SVC), .VEC_HI(VEC)
    ) u_dut (
        .clk(clk), .osc_ok(osc_ok), .ext_rst_n(ext_rst_n),
        .wdog_cfg_en(wdog_cfg_en), .irq_hv(irq_hv), .wdog_tick(wdog_tick),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .core_rst(core_rst), .bus_rdata(bus_rdata)
    );

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk1(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic chk8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic rd, input logic [AW-1:0] a);
        return (rd && a == SVC) ? VEC : 8'h00;
    endfunction

    task automatic do_tick();
        wdog_tick = 1'b1;
        step(1);
        wdog_tick = 1'b0;
    endtask

    task automatic quiet_ticks(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            do_tick();
            chk1(req, "no reset before limit", core_rst, 1'b0);
        end
    endtask

    // Call right after the edge that sampled the final tick.
    task automatic expect_fire(input string req);
        chk1(req, "reset not yet on time-out edge", core_rst, 1'b0);
        step(1);
        chk1(req, "reset first cycle", core_rst, 1'b1);
        step(1);
        chk1(req, "reset second cycle", core_rst, 1'b1);
        step(1);
        chk1(req, "reset released", core_rst, 1'b0);
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        step(1);
        bus_wr    = 1'b0;
    endtask

    task automatic pin_pulse(input logic hv);
        irq_hv    = hv;
        ext_rst_n = 1'b0;
        step(SY + 1);
        chk1("R3", "pin pulse asserts", core_rst, 1'b1);
        ext_rst_n = 1'b1;
        step(SY + 1);
        chk1("R3", "pin pulse releases", core_rst, 1'b0);
        irq_hv = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int mcnt;
        int op;
        logic tk, clr, rd;
        logic [AW-1:0] a;
        logic [7:0] d;

        void'($urandom(32'd20240611));
        osc_ok = 1'b0; ext_rst_n = 1'b1; wdog_cfg_en = 1'b1; irq_hv = 1'b0;
        wdog_tick = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        step(3);
        chk1("R2", "reset while oscillator off", core_rst, 1'b1);
        chk8("R6", "idle read data", bus_rdata, 8'h00);

        // R1: clean power-up
        osc_ok = 1'b1;
        step(P);
        chk1("R1", "held through count", core_rst, 1'b1);
        step(1);
        chk1("R1", "released after count", core_rst, 1'b0);

        // R6: shared address reads
        bus_rd = 1'b1; bus_addr = SVC; #1;
        chk8("R6", "service address read", bus_rdata, VEC);
        bus_addr = SVC ^ 12'h004; #1;
        chk8("R6", "other address read", bus_rdata, 8'h00);
        bus_addr = SVC; bus_rd = 1'b0; #1;
        chk8("R6", "no strobe", bus_rdata, 8'h00);
        step(1);

        // R4: limit, off by one
        quiet_ticks(T - 1, "R4");
        do_tick();
        expect_fire("R4");

        // R5: valid service, then ignored writes
        quiet_ticks(T - 1, "R5");
        bus_write(SVC, 8'hFE);
        quiet_ticks(T - 1, "R5");
        bus_write(SVC, 8'h01);
        bus_rd = 1'b1; bus_addr = SVC; #1;
        chk8("R6", "read unchanged by write", bus_rdata, VEC);
        bus_rd = 1'b0;
        do_tick();
        expect_fire("R5");
        quiet_ticks(T - 1, "R5");
        bus_write(SVC ^ 12'h100, 8'h00);
        do_tick();
        expect_fire("R5");

        // R9: ticks during reset do not count; R3 latency
        ext_rst_n = 1'b0;
        wdog_tick = 1'b1;
        step(SY);
        chk1("R3", "sync latency not yet", core_rst, 1'b0);
        step(1);
        chk1("R3", "pin asserted", core_rst, 1'b1);
        step(20);
        ext_rst_n = 1'b1;
        step(SY);
        chk1("R3", "still held during sync", core_rst, 1'b1);
        wdog_tick = 1'b0;
        step(1);
        chk1("R3", "pin released", core_rst, 1'b0);
        quiet_ticks(T - 1, "R9");
        do_tick();
        expect_fire("R9");

        // R7: configuration off
        wdog_cfg_en = 1'b0;
        quiet_ticks(3 * T, "R7");
        wdog_cfg_en = 1'b1;
        quiet_ticks(T - 1, "R7");
        do_tick();
        expect_fire("R7");

        // R8: over-voltage latched at release, then restored
        pin_pulse(1'b1);
        quiet_ticks(3 * T, "R8");
        pin_pulse(1'b0);
        quiet_ticks(T - 1, "R8");
        do_tick();
        expect_fire("R8");

        // R5/R6: random mix of ticks and writes
        mcnt = 0;
        for (int i = 0; i < 400; i++) begin
            op  = int'($urandom % 8);
            rd  = 1'($urandom % 2);
            a   = ($urandom % 2) ? SVC : (SVC ^ 12'h010);
            d   = 8'($urandom);
            tk  = 1'b0; clr = 1'b0;
            bus_wr = 1'b0;
            case (op)
                0, 1, 2: tk = 1'b1;
                3: begin bus_wr = 1'b1; a = SVC; d[0] = 1'b0; clr = 1'b1; end
                4: begin bus_wr = 1'b1; a = SVC; d[0] = 1'b1; end
                5: begin bus_wr = 1'b1; a = SVC ^ 12'h020; d[0] = 1'b0; end
                6: begin tk = 1'b1; bus_wr = 1'b1; a = SVC; d[0] = 1'b0; clr = 1'b1; end
                default: ;
            endcase
            if (tk && !clr && mcnt == T - 1) begin
                bus_wr = 1'b1; a = SVC; d[0] = 1'b0; clr = 1'b1;
            end
            wdog_tick = tk; bus_rd = rd; bus_addr = a; bus_wdata = d;
            #1;
            chk8("R6", "random read", bus_rdata, exp_rdata(rd, a));
            step(1);
            mcnt = clr ? 0 : (tk ? mcnt + 1 : mcnt);
            chk1("R5", "no time-out in random mix", core_rst, 1'b0);
            wdog_tick = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        end
        quiet_ticks(T - 1 - mcnt, "R5");
        do_tick();
        expect_fire("R5");

        // R3: pin held past the power-on count
        osc_ok = 1'b0; ext_rst_n = 1'b0;
        step(2);
        osc_ok = 1'b1;
        step(P + 5);
        chk1("R3", "pin holds past count", core_rst, 1'b1);
        ext_rst_n = 1'b1;
        step(SY);
        chk1("R3", "held until sync done", core_rst, 1'b1);
        step(1);
        chk1("R3", "released after pin", core_rst, 1'b0);

        // R2: oscillator drop restarts the count
        osc_ok = 1'b0;
        step(1);
        chk1("R2", "oscillator drop asserts", core_rst, 1'b1);
        osc_ok = 1'b1;
        step(100);
        osc_ok = 1'b0;
        step(2);
        osc_ok = 1'b1;
        step(P);
        chk1("R2", "count restarted", core_rst, 1'b1);
        step(1);
        chk1("R2", "released after full count", core_rst, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule